// File: doc/BRIEF.md
# Audio Clock Generator

This block derives three audio timing signals from a single source clock: a master clock, a bit clock and a word (frame) clock. Each output is a registered level that changes only on a source clock edge, so downstream logic can use it either as a divided clock or, more usually, detect its edges as clock enables. The master clock and the bit clock each come from their own integer divider, whose ratio is a 10-bit field.

The word clock is built by counting bit clock periods. A 2-bit phase mode decides the waveform. In single-phase mode, a one-bit-period high pulse starts each frame. In dual-phase mode, the high and low halves are equal and each lasts a programmed number of bit periods. An inversion input flips the polarity of the word clock.

The master clock has its own enable. The bit clock and the word clock share a second enable. Dropping an enable never cuts a pulse short: the affected output finishes its current period and parks low. When the shared enable drops, the bit clock keeps running until the word clock has completed its frame.

Top module: `audclk_gen`

## Requirements
- R1: While `rst` is high, `mclk_out`, `bclk_out` and `wclk_out` are all 0.
- R2: With `mclk_en` high, `mclk_out` has a period of N source cycles. It is high for floor(N/2) cycles and low for the rest. N is the value of `mclk_div` (2 to 1023), and a value of 0 selects N = 1024.
- R3: With `bw_en` high, `bclk_out` follows the same rule as R2, using `bclk_div` for its ratio.
- R4: With `phase_mode` = 0 (single phase), `wclk_out` is high for one bit clock period and then low for W bit clock periods. W is the value of `wclk_div` (1 to 1023), and a value of 0 selects W = 1024.
- R5: With `phase_mode` = 1, 2 or 3 (dual phase), `wclk_out` is high for W bit clock periods and low for W bit clock periods.
- R6: `wclk_out` changes level only on the source clock edge on which `bclk_out` rises, as long as `wclk_inv` is held steady.
- R7: With `wclk_inv` = 1, `wclk_out` is the complement of the waveform of R4 and R5, and it idles high when the word clock is stopped.
- R8: The master clock runs while `bw_en` is low, and it has no effect on the other two outputs. Likewise, `bclk_out` and `wclk_out` run while `mclk_en` is low, and `mclk_out` stays 0.
- R9: When `mclk_en` drops during a high phase, that high phase still lasts its full floor(N/2) cycles. `mclk_out` then stays low.
- R10: When `bw_en` drops, the word clock completes its current frame and then stays at its idle level. The bit clock keeps toggling until that frame ends, and then stops low. If `bw_en` is low on the edge where a frame would restart, no new word clock pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk_en | input | 1 | Master clock enable |
| mclk_div | input | 10 | Master clock divide ratio (0 means 1024) |
| bw_en | input | 1 | Shared bit clock / word clock enable |
| bclk_div | input | 10 | Bit clock divide ratio (0 means 1024) |
| wclk_div | input | 10 | Word clock length in bit periods (0 means 1024) |
| phase_mode | input | 2 | 0 selects single phase; 1, 2 and 3 select dual phase |
| wclk_inv | input | 1 | Inverts the word clock output |
| mclk_out | output | 1 | Master clock level |
| bclk_out | output | 1 | Bit clock level |
| wclk_out | output | 1 | Word clock level |

## Verification
A shared-enable drop can land on the same edge on which the word clock finishes a frame and would start the next one. That edge has to resolve in favour of stopping, while the bit clock still begins one more period. The bench provokes this by watching a word clock rise and computing the frame length from the requirements. It then drops `bw_en` exactly one cycle before the next rise, and in a second run exactly on the edge of that rise. In the first case it judges that no further word clock pulse appears. In the second case it judges that the pulse already started runs for its full length before everything parks low.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

  // Word clock waveform selection
  typedef enum logic [1:0] {
    PH_SINGLE = 2'd0,
    PH_DUAL   = 2'd1,
    PH_DUAL_B = 2'd2,
    PH_DUAL_C = 2'd3
  } phase_e;

endpackage

// File: rtl/audclk_div.sv
// Integer divider with a registered level output. The high half is floor(N/2)
// cycles; an odd ratio leaves the extra cycle in the low half. Disabling takes
// effect only at a period boundary.
module audclk_div #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             clk_o,
  output logic             start_o
);

  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] ratio;
  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_inc;
  logic             run;
  logic             last;

  assign ratio   = (div == '0) ? (CNT_W'(1) << DIV_W) : {1'b0, div};
  assign half    = ratio >> 1;
  assign cnt_inc = cnt + CNT_W'(1);
  assign last    = run && (cnt >= ratio - CNT_W'(1));
  // A new period begins on this edge
  assign start_o = en && (!run || last);

  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= 1'b0;
      cnt   <= '0;
      clk_o <= 1'b0;
    end else if (start_o) begin
      run   <= 1'b1;
      cnt   <= '0;
      clk_o <= 1'b1;
    end else if (last) begin
      run   <= 1'b0;
      cnt   <= '0;
      clk_o <= 1'b0;
    end else if (run) begin
      cnt   <= cnt_inc;
      clk_o <= (cnt_inc < half);
    end
  end

endmodule

// File: rtl/audclk_frame.sv
// Word clock sequencer: advances once per bit clock period.
module audclk_frame #(
  parameter int DIV_W = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 tick,
  input  logic [DIV_W-1:0]     wdiv,
  input  audclk_pkg::phase_e   mode,
  input  logic                 inv,
  output logic                 wclk_o,
  output logic                 busy_o
);

  import audclk_pkg::*;

  localparam int LEN_W = DIV_W + 2;

  logic [LEN_W-1:0] words;
  logic [LEN_W-1:0] hi_len;
  logic [LEN_W-1:0] per_len;
  logic [LEN_W-1:0] cnt, cnt_n, cnt_inc;
  logic             run, run_n;
  logic             lvl, lvl_n;

  assign words   = (wdiv == '0) ? (LEN_W'(1) << DIV_W) : LEN_W'(wdiv);
  assign hi_len  = (mode == PH_SINGLE) ? LEN_W'(1) : words;
  assign per_len = (mode == PH_SINGLE) ? (words + LEN_W'(1)) : (words << 1);
  assign cnt_inc = cnt + LEN_W'(1);

  always_comb begin
    run_n = run;
    cnt_n = cnt;
    lvl_n = lvl;
    if (tick) begin
      if (!run) begin
        if (en) begin
          run_n = 1'b1;
          cnt_n = '0;
          lvl_n = 1'b1;
        end
      end else if (cnt >= per_len - LEN_W'(1)) begin
        cnt_n = '0;
        if (en) begin
          lvl_n = 1'b1;
        end else begin
          run_n = 1'b0;
          lvl_n = 1'b0;
        end
      end else begin
        cnt_n = cnt_inc;
        lvl_n = (cnt_inc < hi_len);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      cnt    <= '0;
      lvl    <= 1'b0;
      wclk_o <= 1'b0;
    end else begin
      run    <= run_n;
      cnt    <= cnt_n;
      lvl    <= lvl_n;
      wclk_o <= lvl_n ^ inv;
    end
  end

  assign busy_o = run;

endmodule

// File: rtl/audclk_gen.sv
module audclk_gen #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mclk_en,
  input  logic [DIV_W-1:0] mclk_div,
  input  logic             bw_en,
  input  logic [DIV_W-1:0] bclk_div,
  input  logic [DIV_W-1:0] wclk_div,
  input  logic [1:0]       phase_mode,
  input  logic             wclk_inv,
  output logic             mclk_out,
  output logic             bclk_out,
  output logic             wclk_out
);

  localparam int NUM_DIV = 2;
  localparam int IDX_M   = 0;
  localparam int IDX_B   = 1;

  logic [NUM_DIV-1:0] div_en;
  logic [DIV_W-1:0]   div_val [NUM_DIV];
  logic [NUM_DIV-1:0] div_clk;
  logic [NUM_DIV-1:0] div_start;
  logic               frame_busy;

  // The bit clock stays on while a word clock frame is still in flight
  assign div_en[IDX_M]  = mclk_en;
  assign div_en[IDX_B]  = bw_en | frame_busy;
  assign div_val[IDX_M] = mclk_div;
  assign div_val[IDX_B] = bclk_div;

  generate
    for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
      audclk_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .en      (div_en[g]),
        .div     (div_val[g]),
        .clk_o   (div_clk[g]),
        .start_o (div_start[g])
      );
    end
  endgenerate

  audclk_frame #(.DIV_W(DIV_W)) u_frame (
    .clk    (clk),
    .rst    (rst),
    .en     (bw_en),
    .tick   (div_start[IDX_B]),
    .wdiv   (wclk_div),
    .mode   (audclk_pkg::phase_e'(phase_mode)),
    .inv    (wclk_inv),
    .wclk_o (wclk_out),
    .busy_o (frame_busy)
  );

  assign mclk_out = div_clk[IDX_M];
  assign bclk_out = div_clk[IDX_B];

endmodule

// File: rtl/audclk_gen_chk.sv
module audclk_gen_chk #(
  parameter int DIV_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             mclk_en,
  input logic [DIV_W-1:0] mclk_div,
  input logic             bw_en,
  input logic             wclk_inv,
  input logic             mclk_out,
  input logic             bclk_out,
  input logic             wclk_out,
  input logic             mclk_tick
);

  logic [DIV_W:0]   ratio;
  logic [DIV_W:0]   hi_cnt;
  logic [DIV_W-1:0] div_q;
  logic             stable_q;

  assign ratio = (mclk_div == '0) ? ((DIV_W+1)'(1) << DIV_W) : {1'b0, mclk_div};

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt   <= '0;
      div_q    <= '0;
      stable_q <= 1'b0;
    end else begin
      hi_cnt   <= mclk_out ? hi_cnt + 1'b1 : '0;
      div_q    <= mclk_div;
      stable_q <= mclk_out ? (stable_q && (mclk_div == div_q)) : 1'b1;
    end
  end

  // R1: first cycle after reset, the dividers are still low
  p_reset_low_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mclk_out && !bclk_out));

  // R2: a period start raises the master clock on the next edge
  p_mclk_start_r2: assert property (@(posedge clk) disable iff (rst)
    mclk_tick |=> mclk_out);

  // R2: a high phase under a steady ratio lasts floor(N/2) cycles
  p_mclk_high_len_r2: assert property (@(posedge clk) disable iff (rst)
    ($fell(mclk_out) && stable_q && (mclk_div == div_q)) |-> (hi_cnt == (ratio >> 1)));

  // R6: word clock moves only together with a bit clock rise
  p_wclk_on_bclk_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && ($past(wclk_inv) == $past(wclk_inv, 2)) &&
     (wclk_out != $past(wclk_out))) |-> $rose(bclk_out));

  // R9: a disabled master clock that is low stays low
  p_mclk_park_r9: assert property (@(posedge clk) disable iff (rst)
    (!mclk_en && !mclk_out) |=> !mclk_out);

  // R10: a disabled word clock at its idle level stays there
  p_wclk_park_r10: assert property (@(posedge clk) disable iff (rst)
    (!bw_en && (wclk_out == wclk_inv)) |=> (wclk_out == $past(wclk_inv)));

endmodule

bind audclk_gen audclk_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mclk_en   (mclk_en),
  .mclk_div  (mclk_div),
  .bw_en     (bw_en),
  .wclk_inv  (wclk_inv),
  .mclk_out  (mclk_out),
  .bclk_out  (bclk_out),
  .wclk_out  (wclk_out),
  .mclk_tick (div_start[0])
);

// File: tb/test_audclk_gen.sv
`timescale 1ns/1ps
module test_audclk_gen;

  localparam int DIV_W = 10;
  localparam int WAIT_MAX = 6000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             mclk_en = 1'b0;
  logic [DIV_W-1:0] mclk_div = '0;
  logic             bw_en = 1'b0;
  logic [DIV_W-1:0] bclk_div = '0;
  logic [DIV_W-1:0] wclk_div = '0;
  logic [1:0]       phase_mode = '0;
  logic             wclk_inv = 1'b0;
  logic             mclk_out, bclk_out, wclk_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  audclk_gen #(.DIV_W(DIV_W)) i_audclk_gen (
    .clk(clk), .rst(rst), .mclk_en(mclk_en), .mclk_div(mclk_div),
    .bw_en(bw_en), .bclk_div(bclk_div), .wclk_div(wclk_div),
    .phase_mode(phase_mode), .wclk_inv(wclk_inv),
    .mclk_out(mclk_out), .bclk_out(bclk_out), .wclk_out(wclk_out)
  );

  // ---------------- expected values from the requirements ----------------
  function automatic int ratio_of(input int d);
    return (d == 0) ? 1024 : d;
  endfunction
  function automatic int hi_of(input int d);
    return ratio_of(d) / 2;
  endfunction
  function automatic int lo_of(input int d);
    return ratio_of(d) - ratio_of(d) / 2;
  endfunction
  function automatic int w_hi(input int mode, input int wd, input int bd);
    return ((mode == 0) ? 1 : ratio_of(wd)) * ratio_of(bd);
  endfunction
  function automatic int w_lo(input int mode, input int wd, input int bd);
    return ratio_of(wd) * ratio_of(bd);
  endfunction

  function automatic bit sig(input int sel);
    case (sel)
      0: return mclk_out;
      1: return bclk_out;
      default: return wclk_out;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Active level duration, then inactive duration, in source cycles
  task automatic measure(input int sel, input bit pol, output int act, output int inact);
    int n;
    act = -1; inact = -1;
    n = 0;
    while (sig(sel) == pol && n < WAIT_MAX) begin @(negedge clk); n++; end
    n = 0;
    while (sig(sel) != pol && n < WAIT_MAX) begin @(negedge clk); n++; end
    if (n >= WAIT_MAX) return;
    act = 0;
    while (sig(sel) == pol && act < WAIT_MAX) begin act++; @(negedge clk); end
    inact = 0;
    while (sig(sel) != pol && inact < WAIT_MAX) begin inact++; @(negedge clk); end
  endtask

  task automatic settle_measure(input int sel, input bit pol, output int act, output int inact);
    int a0, i0;
    measure(sel, pol, a0, i0);
    measure(sel, pol, act, inact);
  endtask

  task automatic wait_rise(input int sel);
    bit prev;
    int n;
    prev = sig(sel);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (!prev && sig(sel)) break;
      if (n > WAIT_MAX) break;
      prev = sig(sel);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000 && !done) begin
        checks++;
        errors++;
        $display("FAIL watchdog actual %0d expected below 190000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int a, b, cnt, rises, quiet, viol;
    int m, wd, bd;
    bit iv, prev_w, prev_b;
    void'($urandom(32'd1357));

    // R1: reset state
    repeat (4) @(negedge clk);
    mclk_en = 1'b1; bw_en = 1'b1; mclk_div = 10'd4; bclk_div = 10'd2;
    repeat (3) @(negedge clk);
    chk("R1 mclk in reset", mclk_out, 0);
    chk("R1 bclk in reset", bclk_out, 0);
    chk("R1 wclk in reset", wclk_out, 0);
    mclk_en = 1'b0; bw_en = 1'b0;
    @(negedge clk);
    rst = 1'b0;

    // R2 and R8: master clock alone, odd ratio and the zero code
    mclk_en = 1'b1; mclk_div = 10'd7;
    settle_measure(0, 1'b1, a, b);
    chk("R2 div7 high", a, 3);
    chk("R2 div7 low", b, 4);
    chk("R8 bclk idle while bw_en low", bclk_out, 0);
    chk("R8 wclk idle while bw_en low", wclk_out, 0);
    mclk_div = 10'd0;
    settle_measure(0, 1'b1, a, b);
    chk("R2 div0 high", a, 512);
    chk("R2 div0 low", b, 512);

    // R2: random ratios
    for (int t = 0; t < 6; t++) begin
      int d;
      d = $urandom_range(1023, 2);
      mclk_div = DIV_W'(d);
      settle_measure(0, 1'b1, a, b);
      chk("R2 random high", a, hi_of(d));
      chk("R2 random low", b, lo_of(d));
    end

    // R9: disable in the middle of a high phase
    mclk_div = 10'd10;
    settle_measure(0, 1'b1, a, b);
    wait_rise(0);
    cnt = 1;
    repeat (2) begin @(negedge clk); if (mclk_out) cnt++; end
    mclk_en = 1'b0;
    while (mclk_out && cnt < WAIT_MAX) begin @(negedge clk); if (mclk_out) cnt++; end
    chk("R9 last high phase full length", cnt, 5);
    cnt = 0;
    repeat (40) begin @(negedge clk); if (mclk_out) cnt++; end
    chk("R9 mclk parked low", cnt, 0);

    // R4 and R3: single phase, long frame, fast bit clock
    bw_en = 1'b1; phase_mode = 2'd0; bclk_div = 10'd2; wclk_div = 10'd0;
    settle_measure(2, 1'b1, a, b);
    chk("R4 wdiv0 high", a, 2);
    chk("R4 wdiv0 low", b, 2048);
    settle_measure(1, 1'b1, a, b);
    chk("R3 div2 high", a, 1);
    chk("R3 div2 low", b, 1);
    chk("R8 mclk idle while mclk_en low", mclk_out, 0);

    // R3: zero code for the bit clock
    wclk_div = 10'd1; bclk_div = 10'd0;
    settle_measure(1, 1'b1, a, b);
    chk("R3 div0 high", a, 512);
    chk("R3 div0 low", b, 512);

    // R4, R5, R7, R3: random word clock configurations
    for (int t = 0; t < 8; t++) begin
      m  = $urandom_range(3, 0);
      bd = $urandom_range(9, 2);
      wd = $urandom_range(15, 1);
      iv = 1'($urandom_range(1, 0));
      phase_mode = 2'(m); bclk_div = DIV_W'(bd); wclk_div = DIV_W'(wd); wclk_inv = iv;
      settle_measure(2, !iv, a, b);
      if (m == 0) begin
        chk(iv ? "R7 R4 inverted active" : "R4 single active", a, w_hi(m, wd, bd));
        chk(iv ? "R7 R4 inverted idle" : "R4 single idle", b, w_lo(m, wd, bd));
      end else begin
        chk(iv ? "R7 R5 inverted active" : "R5 dual active", a, w_hi(m, wd, bd));
        chk(iv ? "R7 R5 inverted idle" : "R5 dual idle", b, w_lo(m, wd, bd));
      end
      measure(1, 1'b1, a, b);
      chk("R3 random high", a, hi_of(bd));
      chk("R3 random low", b, lo_of(bd));
    end

    // R6: word clock edges coincide with bit clock rises
    wclk_inv = 1'b0; phase_mode = 2'd1; bclk_div = 10'd5; wclk_div = 10'd3;
    settle_measure(2, 1'b1, a, b);
    viol = 0;
    prev_w = wclk_out; prev_b = bclk_out;
    repeat (300) begin
      @(negedge clk);
      if (wclk_out != prev_w && !(bclk_out && !prev_b)) viol++;
      prev_w = wclk_out; prev_b = bclk_out;
    end
    chk("R6 word edges without bit rise", viol, 0);

    // R10: shared enable dropped during a word clock high phase
    phase_mode = 2'd1; bclk_div = 10'd4; wclk_div = 10'd3;
    settle_measure(2, 1'b1, a, b);
    wait_rise(2);
    cnt = 1;
    repeat (2) begin @(negedge clk); if (wclk_out) cnt++; end
    bw_en = 1'b0;
    while (wclk_out && cnt < WAIT_MAX) begin @(negedge clk); if (wclk_out) cnt++; end
    chk("R10 word high phase full length", cnt, 12);
    rises = 0; quiet = 0; prev_b = bclk_out;
    repeat (300) begin
      @(negedge clk);
      if (bclk_out && !prev_b) rises++;
      quiet = (bclk_out != prev_b || bclk_out) ? 0 : quiet + 1;
      prev_b = bclk_out;
    end
    chk("R10 bit clock ran through frame", int'(rises >= 3), 1);
    chk("R10 bit clock parked low", int'(quiet >= 100), 1);
    chk("R10 word clock parked", wclk_out, 0);

    // R7: stopped word clock idles high when inverted
    wclk_inv = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 inverted idle level", wclk_out, 1);
    wclk_inv = 1'b0;

    // R10: disable on the edge where the frame would restart
    phase_mode = 2'd0; bclk_div = 10'd3; wclk_div = 10'd2; bw_en = 1'b1;
    settle_measure(2, 1'b1, a, b);
    wait_rise(2);
    repeat (8) @(negedge clk);
    bw_en = 1'b0;
    cnt = 0;
    repeat (60) begin @(negedge clk); if (wclk_out) cnt++; end
    chk("R10 no pulse after boundary disable", cnt, 0);

    // R10: disable one edge later, the started pulse completes
    bw_en = 1'b1;
    settle_measure(2, 1'b1, a, b);
    wait_rise(2);
    repeat (9) @(negedge clk);
    chk("R10 next frame started", wclk_out, 1);
    bw_en = 1'b0;
    cnt = 1;
    while (wclk_out && cnt < WAIT_MAX) begin @(negedge clk); if (wclk_out) cnt++; end
    chk("R10 started pulse full length", cnt, 3);
    repeat (60) @(negedge clk);
    chk("R10 bit clock stopped", bclk_out, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule